// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

The block decides which receive message buffer accepts an incoming CAN frame. A pulse on `start_i` captures the frame identifier, its extended-format flag, the three acceptance masks and the mode bit. The block then walks the buffer table, one entry per clock, from index 0 upward. Each enabled buffer is compared with the captured frame under the mask that belongs to that buffer index.

Two buffer indices each have a dedicated mask. Every other buffer uses the shared global mask. One 29-bit mask layout serves both identifier formats. For a base-format frame, only the upper 11 bit positions take part in the comparison. When the individual mode bit is set, masking is bypassed and the identifier must match exactly.

When the scan ends, the block raises `done_o` for one cycle. At that point `hit_o` and `idx_o` give the result: the lowest-numbered buffer that accepted the frame.

Top module: `can_accept_filter`

## Requirements
- R1: Buffer index DED_A (default 14) is compared under `mask_a_i` and buffer index DED_B (default 15) under `mask_b_i`. Every other buffer is compared under `gmask_i`.
- R2: A mask bit of 0 makes that identifier bit don't-care. A mask bit of 1 requires the frame bit to equal the buffer bit. Bit 28 of every 29-bit vector is the most significant identifier bit.
- R3: When `frame_ide_i`=0 (base format), only bits 28..18 of the identifiers and mask are compared, and bits 17..0 are ignored.
- R4: A buffer accepts a frame only if its IDE bit (`buf_ide_i[b]`) equals the frame's IDE bit, whatever the mask contents.
- R5: A buffer with `buf_en_i[b]`=0 never accepts a frame.
- R6: When several buffers accept, `idx_o` reports the lowest index.
- R7: With `indiv_mode_i`=1 captured, all masks are ignored and all 29 bits must be equal (bits 28..18 only for a base-format frame).
- R8: The frame ID, IDE, masks and mode are sampled at the accepted start. Changing them during a scan does not alter that scan's result.
- R9: `done_o` pulses for exactly one cycle, NUM_BUF clock edges after the edge that accepts `start_i`. `busy_o` is high throughout the scan and low in the cycle `done_o` is high.
- R10: A `start_i` pulse while `busy_o`=1 is ignored. It neither restarts the scan nor produces an extra `done_o`.
- R11: If no buffer accepts, `hit_o`=0 and `idx_o`=0 at done. `hit_o` and `idx_o` hold their values until the next accepted start.
- R12: After reset, `busy_o`, `done_o`, `hit_o` and `idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (accepted when idle) |
| frame_id_i | input | 29 | Received identifier, bit 28 is the MSB |
| frame_ide_i | input | 1 | 1 = extended frame, 0 = base frame |
| buf_en_i | input | NUM_BUF | Per-buffer receive enable |
| buf_ide_i | input | NUM_BUF | Per-buffer IDE bit |
| buf_id_i | input | NUM_BUF*29 | Buffer identifiers, buffer b at bits [b*29 +: 29] |
| gmask_i | input | 29 | Shared acceptance mask |
| mask_a_i | input | 29 | Mask for buffer DED_A |
| mask_b_i | input | 29 | Mask for buffer DED_B |
| indiv_mode_i | input | 1 | 1 = exact compare, masks bypassed |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | A buffer accepted the frame |
| idx_o | output | $clog2(NUM_BUF) | Index of the accepting buffer |

## Verification
The bench builds the block with its default parameters: 64 buffers, with the dedicated masks at indices 14 and 15. This makes both dedicated-mask slots reachable, along with the buffers on either side of them that fall back to the global mask, and the last index, 63. Scans with random tables check priority and the format handling across the full index range. The scan length of 64 cycles leaves room to change the masks, and to re-pulse start, in the middle of a scan.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  typedef logic [ID_W-1:0] can_id_t;
  // base-format frames compare only the top STD_W bits
  localparam can_id_t STD_KEEP = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};
endpackage

// File: rtl/can_mask_select.sv
module can_mask_select
  import can_filt_pkg::*;
#(
  parameter int NUM_BUF = 64,
  parameter int DED_A   = 14,
  parameter int DED_B   = 15,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  can_id_t          gmask_i,
  input  can_id_t          mask_a_i,
  input  can_id_t          mask_b_i,
  input  logic             indiv_i,
  input  logic             ext_i,
  output can_id_t          mask_o
);
  localparam logic [IDX_W-1:0] IdxA = IDX_W'(DED_A);
  localparam logic [IDX_W-1:0] IdxB = IDX_W'(DED_B);

  can_id_t base_mask;

  always_comb begin
    if (indiv_i)           base_mask = '1;
    else if (idx_i == IdxA) base_mask = mask_a_i;
    else if (idx_i == IdxB) base_mask = mask_b_i;
    else                    base_mask = gmask_i;
    mask_o = ext_i ? base_mask : (base_mask & STD_KEEP);
  end
endmodule

// File: rtl/can_id_compare.sv
module can_id_compare
  import can_filt_pkg::*;
(
  input  can_id_t frame_id_i,
  input  logic    frame_ide_i,
  input  can_id_t buf_id_i,
  input  logic    buf_ide_i,
  input  logic    buf_en_i,
  input  can_id_t mask_i,
  output logic    match_o
);
  can_id_t diff;

  always_comb begin
    diff    = (frame_id_i ^ buf_id_i) & mask_i;
    match_o = buf_en_i && (buf_ide_i == frame_ide_i) && (diff == '0);
  end
endmodule

// File: rtl/can_scan_ctrl.sv
module can_scan_ctrl #(
  parameter int NUM_BUF = 64,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             match_i,
  output logic             cap_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] Last = IDX_W'(NUM_BUF - 1);

  assign cap_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      done_o <= 1'b0;
      hit_o  <= 1'b0;
      idx_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (cap_o) begin
        busy_o <= 1'b1;
        cnt_o  <= '0;
        hit_o  <= 1'b0;
        idx_o  <= '0;
      end else if (busy_o) begin
        // first match in ascending order wins
        if (match_i && !hit_o) begin
          hit_o <= 1'b1;
          idx_o <= cnt_o;
        end
        if (cnt_o == Last) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_BUF = 64,
  parameter int DED_A   = 14,
  parameter int DED_B   = 15,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [ID_W-1:0]         frame_id_i,
  input  logic                    frame_ide_i,
  input  logic [NUM_BUF-1:0]      buf_en_i,
  input  logic [NUM_BUF-1:0]      buf_ide_i,
  input  logic [NUM_BUF*ID_W-1:0] buf_id_i,
  input  logic [ID_W-1:0]         gmask_i,
  input  logic [ID_W-1:0]         mask_a_i,
  input  logic [ID_W-1:0]         mask_b_i,
  input  logic                    indiv_mode_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  can_id_t          buf_id_arr [NUM_BUF];
  logic             cap;
  logic [IDX_W-1:0] cnt;
  logic             match;
  can_id_t          eff_mask;

  can_id_t fid_q, gmask_q, mask_a_q, mask_b_q;
  logic    fide_q, indiv_q;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_unpack
    assign buf_id_arr[g] = buf_id_i[g*ID_W +: ID_W];
  end

  // frame and masks sampled once per search
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fid_q    <= '0;
      fide_q   <= 1'b0;
      gmask_q  <= '0;
      mask_a_q <= '0;
      mask_b_q <= '0;
      indiv_q  <= 1'b0;
    end else if (cap) begin
      fid_q    <= frame_id_i;
      fide_q   <= frame_ide_i;
      gmask_q  <= gmask_i;
      mask_a_q <= mask_a_i;
      mask_b_q <= mask_b_i;
      indiv_q  <= indiv_mode_i;
    end
  end

  can_mask_select #(
    .NUM_BUF(NUM_BUF), .DED_A(DED_A), .DED_B(DED_B)
  ) i_mask_sel (
    .idx_i   (cnt),
    .gmask_i (gmask_q),
    .mask_a_i(mask_a_q),
    .mask_b_i(mask_b_q),
    .indiv_i (indiv_q),
    .ext_i   (fide_q),
    .mask_o  (eff_mask)
  );

  can_id_compare i_cmp (
    .frame_id_i (fid_q),
    .frame_ide_i(fide_q),
    .buf_id_i   (buf_id_arr[cnt]),
    .buf_ide_i  (buf_ide_i[cnt]),
    .buf_en_i   (buf_en_i[cnt]),
    .mask_i     (eff_mask),
    .match_o    (match)
  );

  can_scan_ctrl #(.NUM_BUF(NUM_BUF)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .match_i(match),
    .cap_o  (cap),
    .cnt_o  (cnt),
    .busy_o (busy_o),
    .done_o (done_o),
    .hit_o  (hit_o),
    .idx_o  (idx_o)
  );
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NUM_BUF = 64,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int LAT_W  = $clog2(NUM_BUF + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] idx_o
);
  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat <= '0;
    else if (start_i && !busy_o) lat <= '0;
    else if (busy_o)             lat <= lat + 1'b1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_scan_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat == LAT_W'(NUM_BUF)));

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(hit_o) && $stable(idx_o)));

  assert_no_idx_without_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (idx_o == '0));
endmodule

bind can_accept_filter can_accept_filter_chk #(.NUM_BUF(NUM_BUF)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .hit_o  (hit_o),
  .idx_o  (idx_o)
);

// File: tb/test_can_accept_filter.sv
`timescale 1ns/1ps
module test_can_accept_filter;
  localparam int NB   = 64;
  localparam int IW   = 29;
  localparam int XW   = $clog2(NB);
  localparam logic [IW-1:0] STDM = 29'h1FFC_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start;
  logic [IW-1:0] fid, gm, ma, mb;
  logic          fide, ind;
  logic [NB-1:0] ben, bide;
  logic [IW-1:0] bid [NB];
  logic [NB*IW-1:0] bid_flat;
  logic          busy, done, hit;
  logic [XW-1:0] idx;

  always_comb
    for (int b = 0; b < NB; b++) bid_flat[b*IW +: IW] = bid[b];

  can_accept_filter #(.NUM_BUF(NB)) i_can_accept_filter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .frame_id_i(fid), .frame_ide_i(fide),
    .buf_en_i(ben), .buf_ide_i(bide), .buf_id_i(bid_flat),
    .gmask_i(gm), .mask_a_i(ma), .mask_b_i(mb), .indiv_mode_i(ind),
    .busy_o(busy), .done_o(done), .hit_o(hit), .idx_o(idx)
  );

  typedef struct { logic hit; logic [XW-1:0] idx; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic exp_t model(input string tag);
    exp_t e;
    logic [IW-1:0] m;
    e.hit = 1'b0; e.idx = '0; e.tag = tag;
    for (int b = 0; b < NB; b++) begin
      if (!e.hit && ben[b] && bide[b] == fide) begin
        m = ind ? '1 : (b == 14 ? ma : (b == 15 ? mb : gm));
        if (!fide) m = m & STDM;
        if (((fid ^ bid[b]) & m) == '0) begin
          e.hit = 1'b1;
          e.idx = XW'(b);
        end
      end
    end
    return e;
  endfunction

  // monitor: pop one expected item per done strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      if (q.size() == 0) begin
        chk(1'b0, "R10", "done with no pending search");
      end else begin
        e = q.pop_front();
        chk(hit == e.hit && idx == e.idx, e.tag,
            $sformatf("hit/idx act %0b/%0d exp %0b/%0d", hit, idx, e.hit, e.idx));
      end
    end
  end

  task automatic clear_tab();
    ben = '0; bide = '0;
    for (int b = 0; b < NB; b++) bid[b] = '0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  task automatic launch(input string tag);
    @(negedge clk);
    start = 1'b1;
    q.push_back(model(tag));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic search(input string tag);
    launch(tag);
    wait_done();
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    start = 0; fid = '0; fide = 0; gm = '0; ma = '0; mb = '0; ind = 0;
    clear_tab();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !hit && idx == '0, "R12", "outputs not clear in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !hit && idx == '0, "R12",
        $sformatf("after reset busy/done/hit/idx %0b/%0b/%0b/%0d exp 0", busy, done, hit, idx));

    // R2 global mask don't-care bits, extended frame
    fide = 1; fid = 29'h0ABC_1234; gm = 29'h1FFF_FF00;
    ben[20] = 1; bide[20] = 1; bid[20] = 29'h0ABC_12FF;
    search("R2");
    // R2 a checked bit differs -> miss
    bid[20] = 29'h0ABC_02FF;
    search("R2");

    // R1 buffer 14 under mask_a only; 13 and 16 under global reject
    clear_tab();
    fid = 29'h1555_5555; gm = '1; ma = 29'h1FFF_0000; mb = '1;
    for (int b = 13; b <= 16; b++) begin ben[b] = 1; bide[b] = 1; bid[b] = 29'h1555_AAAA; end
    search("R1");
    // R1 buffer 15 under mask_b
    ma = '1; mb = 29'h1FFF_0000;
    search("R1");

    // R3 base frame ignores low 18 bits even with full mask
    clear_tab();
    fide = 0; gm = '1; fid = {11'h5A5, 18'h00000};
    ben[33] = 1; bid[33] = {11'h5A5, 18'h3FFFF};
    search("R3");
    bid[33] = {11'h5A4, 18'h00000};
    search("R3");

    // R4 identical id but IDE differs -> no hit (R11 idx 0)
    clear_tab();
    fide = 1; fid = 29'h0123_4567; gm = '0;
    ben[7] = 1; bide[7] = 0; bid[7] = fid;
    search("R4");
    chk(!hit && idx == '0, "R11", $sformatf("no-hit hold act %0b/%0d exp 0/0", hit, idx));

    // R5 disabled buffer skipped, next enabled one wins
    clear_tab();
    gm = '1;
    bide = '1; bid[2] = fid; bid[40] = fid; ben[40] = 1;
    search("R5");

    // R6 lowest of several matches
    ben[2] = 1; ben[63] = 1; bid[63] = fid;
    search("R6");

    // R7 individual mode: masked match at 5 rejected, exact at 63 wins
    clear_tab();
    bide = '1; gm = '0; ma = '0; mb = '0; ind = 1;
    ben[5] = 1; bid[5] = fid ^ 29'h1; ben[63] = 1; bid[63] = fid;
    search("R7");
    ind = 0;
    search("R7");

    // R8 change frame/masks mid-scan
    clear_tab();
    gm = '1; bide = '1; ben[50] = 1; bid[50] = fid;
    launch("R8");
    repeat (10) @(negedge clk);
    fid = ~fid; gm = '1; ind = 1; fide = 0;
    wait_done();
    fide = 1; ind = 0;

    // R10 restart attempt mid-scan ignored; R9 latency
    fid = bid[50];
    begin
      int n = 0;
      @(negedge clk);
      start = 1'b1;
      q.push_back(model("R10"));
      @(negedge clk);
      start = 1'b0;
      n = 1;
      repeat (5) begin @(negedge clk); n++; end
      start = 1'b1; fid = '0;
      @(negedge clk); n++;
      start = 1'b0;
      chk(busy, "R9", "busy dropped mid-scan");
      while (!done) begin @(negedge clk); n++; end
      chk(n == NB + 1, "R9", $sformatf("latency act %0d exp %0d", n, NB + 1));
      @(negedge clk);
      chk(!done && !busy, "R9", "done not single-cycle");
      repeat (NB + 5) @(negedge clk);
      chk(q.size() == 0 && !busy, "R10", $sformatf("pending act %0d exp 0", q.size()));
      chk(hit && idx == 6'd50, "R11", $sformatf("hold act %0b/%0d exp 1/50", hit, idx));
    end

    // random tables, both formats
    for (int t = 0; t < 30; t++) begin
      fide = 1'($urandom); ind = ($urandom % 5) == 0;
      fid = 29'($urandom);
      gm = 29'($urandom) | 29'($urandom); ma = 29'($urandom); mb = 29'($urandom);
      for (int b = 0; b < NB; b++) begin
        ben[b] = ($urandom % 3) != 0;
        bide[b] = ($urandom % 4) == 0 ? ~fide : fide;
        bid[b] = fid ^ (29'h1 << ($urandom % 29)) ^ (($urandom % 3 == 0) ? 29'h0 : 29'(1 << ($urandom % 29)));
        if ($urandom % 8 == 0) bid[b] = fid;
      end
      search("R6");
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9", $sformatf("leftover expected items %0d exp 0", q.size()));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule